// File: doc/BRIEF.md
# Sixteen-Function Bitwise Logic Unit

This block is a purely combinational bitwise logic unit. Every bit position of two N-bit operands passes through the same two-input Boolean function. The caller picks one of all sixteen possible functions of two variables with a 4-bit code. The code is the function's own truth-table column, so each output bit is a 4:1 selection from the code, steered by the operand bit pair. A reduced mode accepts a compact 3-bit select for the eight common gates.

A mask mode uses the same function cells for the usual field-manipulation idioms. It clears, sets or flips the bits that a mask picks out. It also inserts a new value into a field in two passes: the first pass zeroes the field through the mask, and the second ORs in the new value. Nothing is registered. The result follows the inputs within the same cycle.

Top module: `lu_top`

## Requirements
- R1: With modeSel = 00, result bit i equals funcCode[3 - 2*opX[i] - opY[i]] for every bit i (the code lists the outputs for input pairs 11, 10, 01, 00 from bit 0 up to bit 3).
- R2: In full mode the named codes give these results: 1 AND, 2 X&~Y, 3 X, 4 ~X&Y, 5 Y, 6 XOR, 7 OR, 8 NOR, 9 XNOR, 10 ~Y, 11 X|~Y, 12 ~X, 13 ~X|Y, 14 NAND.
- R3: Code 0 gives all zeros and code 15 gives all ones, whatever the operands.
- R4: With modeSel = 01, funcCode[2:0] selects 000 AND, 001 OR, 010 XOR, 011 ~X, 100 NAND, 101 NOR, 110 XNOR, 111 ~Y, and funcCode[3] has no effect.
- R5: With modeSel = 10 and funcCode[1:0] = 00 (clear), result = opX & opY, so zeros in the mask opY clear those bits.
- R6: With modeSel = 10 and funcCode[1:0] = 01 (set), result = opX | opY.
- R7: With modeSel = 10 and funcCode[1:0] = 10 (flip), result = opX ^ opY.
- R8: With modeSel = 10 and funcCode[1:0] = 11 (insert), result = (opX & opY) | insVal. For example, 0x6A with mask 0x0F and value 0x90 gives 0x9A.
- R9: In mask mode funcCode[3:2] has no effect, and insVal affects the result only in insert.
- R10: modeSel = 11 behaves the same as modeSel = 00.
- R11: The result is combinational: it reflects new inputs before any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opX | input | WIDTH | First operand, and the target in mask mode |
| opY | input | WIDTH | Second operand, and the mask in mask mode |
| insVal | input | WIDTH | Field value ORed in by insert |
| funcCode | input | 4 | Function column, reduced select, or mask operation |
| modeSel | input | 2 | 00/11 full, 01 reduced, 10 mask |
| result | output | WIDTH | Bitwise result |

## Verification
The bench builds the unit with WIDTH = 8. At that width the insert example from the requirements appears byte for byte, and random 8-bit operands quickly cover all four bit-pair combinations in every code. Each of the sixteen columns is swept over random operands, along with the all-zero and all-one operand corners. The ignored code bits and the ignored insert value are toggled while the output is watched.

// File: rtl/lu_pkg.sv
package lu_pkg;

  typedef enum logic [1:0] {
    MODE_FULL    = 2'b00,
    MODE_REDUCED = 2'b01,
    MODE_MASK    = 2'b10,
    MODE_ALIAS   = 2'b11
  } lu_mode_e;

  typedef enum logic [1:0] {
    MOP_CLEAR  = 2'b00,
    MOP_SET    = 2'b01,
    MOP_FLIP   = 2'b10,
    MOP_INSERT = 2'b11
  } mask_op_e;

  localparam logic [3:0] COL_AND   = 4'd1;
  localparam logic [3:0] COL_PASSX = 4'd3;
  localparam logic [3:0] COL_XOR   = 4'd6;
  localparam logic [3:0] COL_OR    = 4'd7;
  localparam logic [3:0] COL_NOR   = 4'd8;
  localparam logic [3:0] COL_XNOR  = 4'd9;
  localparam logic [3:0] COL_NOTY  = 4'd10;
  localparam logic [3:0] COL_NOTX  = 4'd12;
  localparam logic [3:0] COL_NAND  = 4'd14;

  typedef struct packed {
    logic [3:0] firstCode;
    logic [3:0] secondCode;
    logic       useIns;
  } lu_strobe_t;

  function automatic logic [3:0] reducedColumn(input logic [2:0] sel);
    case (sel)
      3'd0:    reducedColumn = COL_AND;
      3'd1:    reducedColumn = COL_OR;
      3'd2:    reducedColumn = COL_XOR;
      3'd3:    reducedColumn = COL_NOTX;
      3'd4:    reducedColumn = COL_NAND;
      3'd5:    reducedColumn = COL_NOR;
      3'd6:    reducedColumn = COL_XNOR;
      default: reducedColumn = COL_NOTY;
    endcase
  endfunction

endpackage

// File: rtl/lu_stage.sv
module lu_stage #(
  parameter int WIDTH = 16
) (
  input  logic [3:0]       code,
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  output logic [WIDTH-1:0] out
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    logic [1:0] pickIdx;
    assign pickIdx = {~x[i], ~y[i]};
    assign out[i]  = code[pickIdx];
  end

  always_comb begin
    if (code == 4'd0)  AST_ZERO_COLUMN: assert (out == '0) else $error("zero column");        // R3
    if (code == 4'd15) AST_ONE_COLUMN:  assert (out == ALL_ONES) else $error("one column");   // R3
    if (code == 4'd3)  AST_PASS_X:      assert (out == x) else $error("pass x");              // R2
    if (code == 4'd5)  AST_PASS_Y:      assert (out == y) else $error("pass y");              // R2
  end

endmodule

// File: rtl/lu_ctrl.sv
module lu_ctrl
  import lu_pkg::*;
(
  input  logic [3:0]  funcCode,
  input  logic [1:0]  modeSel,
  output lu_strobe_t  strobe
);

  lu_mode_e modeNow;
  mask_op_e maskOp;

  assign modeNow = lu_mode_e'(modeSel);
  assign maskOp  = mask_op_e'(funcCode[1:0]);

  always_comb begin
    strobe.firstCode  = funcCode;
    strobe.secondCode = COL_PASSX;
    strobe.useIns     = 1'b0;
    case (modeNow)
      MODE_REDUCED: strobe.firstCode = reducedColumn(funcCode[2:0]);
      MODE_MASK: begin
        case (maskOp)
          MOP_CLEAR: strobe.firstCode = COL_AND;
          MOP_SET:   strobe.firstCode = COL_OR;
          MOP_FLIP:  strobe.firstCode = COL_XOR;
          default: begin
            strobe.firstCode  = COL_AND;
            strobe.secondCode = COL_OR;
            strobe.useIns     = 1'b1;
          end
        endcase
      end
      default: strobe.firstCode = funcCode;
    endcase
  end

  always_comb begin
    AST_SECOND_PASS: assert (strobe.secondCode == COL_PASSX || strobe.secondCode == COL_OR)
      else $error("second pass code");                                                        // R8
    if (modeNow != MODE_MASK)
      AST_NO_INSERT: assert (!strobe.useIns) else $error("insert outside mask mode");         // R9
  end

endmodule

// File: rtl/lu_datapath.sv
module lu_datapath
  import lu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  lu_strobe_t       strobe,
  input  logic [WIDTH-1:0] opX,
  input  logic [WIDTH-1:0] opY,
  input  logic [WIDTH-1:0] insVal,
  output logic [WIDTH-1:0] result
);

  logic [WIDTH-1:0] firstOut;
  logic [WIDTH-1:0] secondY;

  assign secondY = strobe.useIns ? insVal : '0;

  lu_stage #(.WIDTH(WIDTH)) uFirst (
    .code (strobe.firstCode),
    .x    (opX),
    .y    (opY),
    .out  (firstOut)
  );

  lu_stage #(.WIDTH(WIDTH)) uSecond (
    .code (strobe.secondCode),
    .x    (firstOut),
    .y    (secondY),
    .out  (result)
  );

  always_comb begin
    if (!strobe.useIns)
      AST_SECOND_TRANSPARENT: assert (result == firstOut) else $error("second pass altered"); // R9
    else
      AST_INSERT_KEEPS: assert ((result & firstOut) == firstOut) else $error("insert lost bits"); // R8
  end

endmodule

// File: rtl/lu_top.sv
module lu_top
  import lu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opX,
  input  logic [WIDTH-1:0] opY,
  input  logic [WIDTH-1:0] insVal,
  input  logic [3:0]       funcCode,
  input  logic [1:0]       modeSel,
  output logic [WIDTH-1:0] result
);

  lu_strobe_t strobe;

  lu_ctrl uCtrl (
    .funcCode (funcCode),
    .modeSel  (modeSel),
    .strobe   (strobe)
  );

  lu_datapath #(.WIDTH(WIDTH)) uPath (
    .strobe (strobe),
    .opX    (opX),
    .opY    (opY),
    .insVal (insVal),
    .result (result)
  );

endmodule

// File: tb/tb_lu_top.sv
module tb_lu_top;

  localparam int WIDTH = 8;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [WIDTH-1:0] opX = '0, opY = '0, insVal = '0;
  logic [3:0] funcCode = '0;
  logic [1:0] modeSel = '0;
  logic [WIDTH-1:0] result;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lu_top #(.WIDTH(WIDTH)) dut (
    .opX(opX), .opY(opY), .insVal(insVal),
    .funcCode(funcCode), .modeSel(modeSel), .result(result)
  );

  function automatic logic [WIDTH-1:0] refFull(input int k, input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] y);
    case (k)
      0:  return '0;
      1:  return x & y;
      2:  return x & ~y;
      3:  return x;
      4:  return ~x & y;
      5:  return y;
      6:  return x ^ y;
      7:  return x | y;
      8:  return ~(x | y);
      9:  return ~(x ^ y);
      10: return ~y;
      11: return x | ~y;
      12: return ~x;
      13: return ~x | y;
      14: return ~(x & y);
      default: return '1;
    endcase
  endfunction

  function automatic logic [WIDTH-1:0] refReduced(input int s, input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] y);
    case (s)
      0: return x & y;
      1: return x | y;
      2: return x ^ y;
      3: return ~x;
      4: return ~(x & y);
      5: return ~(x | y);
      6: return ~(x ^ y);
      default: return ~y;
    endcase
  endfunction

  task automatic check(input string req, input logic [WIDTH-1:0] got, input logic [WIDTH-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [1:0] m, input logic [3:0] c,
                       input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] y, input logic [WIDTH-1:0] z);
    @(posedge clk);
    modeSel = m; funcCode = c; opX = x; opY = y; insVal = z;
    @(negedge clk);
  endtask

  initial begin
    logic [WIDTH-1:0] x, y, z, first;
    void'($urandom(32'd2024));
    repeat (2) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R3 reset-state zero", result, '0);

    // R1 R2 R3: sweep all columns with random and corner operands
    for (int k = 0; k < 16; k++) begin
      apply(2'b00, 4'(k), 8'h00, 8'hFF, 8'h00);
      check($sformatf("R3 R1 code %0d corner", k), result, refFull(k, 8'h00, 8'hFF));
      apply(2'b00, 4'(k), 8'hCC, 8'hAA, 8'h00);
      check($sformatf("R1 code %0d all pairs", k), result, refFull(k, 8'hCC, 8'hAA));
      for (int n = 0; n < 12; n++) begin
        x = WIDTH'($urandom); y = WIDTH'($urandom);
        apply(2'b00, 4'(k), x, y, WIDTH'($urandom));
        check($sformatf("R2 code %0d random", k), result, refFull(k, x, y));
      end
    end

    // R4 reduced select, bit 3 ignored
    for (int s = 0; s < 8; s++) begin
      for (int n = 0; n < 6; n++) begin
        x = WIDTH'($urandom); y = WIDTH'($urandom);
        apply(2'b01, {1'b0, 3'(s)}, x, y, '0);
        check($sformatf("R4 sel %0d", s), result, refReduced(s, x, y));
        apply(2'b01, {1'b1, 3'(s)}, x, y, '0);
        check($sformatf("R4 sel %0d bit3 set", s), result, refReduced(s, x, y));
      end
    end

    // R5 R6 R7 R8 R9 mask mode
    for (int n = 0; n < 20; n++) begin
      x = WIDTH'($urandom); y = WIDTH'($urandom); z = WIDTH'($urandom);
      apply(2'b10, 4'b0000, x, y, z);
      check("R5 clear", result, x & y);
      apply(2'b10, 4'b1101, x, y, z);
      check("R6 set", result, x | y);
      apply(2'b10, 4'b0110, x, y, z);
      check("R7 flip", result, x ^ y);
      apply(2'b10, 4'b0011, x, y, z);
      check("R8 insert", result, (x & y) | z);
      apply(2'b10, 4'b1111, x, y, z);
      check("R9 upper code bits ignored in insert", result, (x & y) | z);
      apply(2'b10, 4'b1000, x, y, ~z);
      check("R9 insVal ignored in clear", result, x & y);
    end
    apply(2'b10, 4'b0011, 8'h6A, 8'h0F, 8'h90);
    check("R8 insert example", result, 8'h9A);
    apply(2'b10, 4'b0000, 8'hAD, 8'h0F, 8'h00);
    check("R5 clear high nibble", result, 8'h0D);

    // R10 alias mode, R9 insVal ignored outside mask
    for (int k = 0; k < 16; k++) begin
      x = WIDTH'($urandom); y = WIDTH'($urandom);
      apply(2'b11, 4'(k), x, y, 8'hFF);
      check($sformatf("R10 alias code %0d", k), result, refFull(k, x, y));
    end

    // R11 combinational: change inputs mid-cycle, no edge in between
    @(negedge clk);
    modeSel = 2'b00; funcCode = 4'd6; opX = 8'hF0; opY = 8'h3C;
    #1;
    check("R11 same-cycle xor", result, 8'hCC);
    funcCode = 4'd14;
    #1;
    check("R11 same-cycle nand", result, 8'hCF);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule